// File: doc/BRIEF.md
# Gated Divided Serial Clock Generator

This block produces a serial bit clock for an external sigma-delta modulator. It divides one of two sources, the system clock or an asynchronous audio clock, by a programmable ratio. The clock on the pin can be switched off in two ways: a zero ratio, or clearing the enable. When the enable is cleared, the clock stops after a fixed number of source cycles, and it never leaves a shortened high pulse on the pin.

The source choice can only change while the block is idle. The choice is sampled only when the enable is low and the stopped status is high. A value presented on the select input at any other time has no effect, so the pin never sees a clock switch. The stop-request pipeline for the audio source also serves as its clock-domain synchroniser. The idle state of the audio divider is synchronised back into the system domain to drive the status output. The divider ratio and the source select are expected to be static while the clock runs. The pin frequency that results must stay within 0 to 20 MHz, and setting the ratio to meet this is the integrator's job.

Top module: `sclk_gen`

## Requirements
- R1: After reset, sclk_o is low, stopped_o is high and the system clock is the selected source.
- R2: With a nonzero ratio field D, the pin period is N = D+1 source cycles. The pin is high for floor(N/2) cycles and low for the rest.
- R3: With the ratio field at zero, sclk_o stays low and stopped_o stays high even while en_i is high.
- R4: System source: call edge 0 the first clk_i edge that samples en_i low. The divider still advances on edges 1 to 3, and sclk_o has no rising edge from edge 4 onward.
- R5: Audio source: after edge 0 (one system edge), the divider still advances on the first three aud_clk_i edges. From the fourth aud_clk_i edge onward, sclk_o has no rising edge.
- R6: A stop never shortens a high phase. The last high pulse before the pin settles low lasts the full floor(N/2) source cycles.
- R7: A start begins with a full low phase. If edge 0 is the first clk_i edge that samples en_i high (system source), the first rising edge of sclk_o is at edge 3 + (N - floor(N/2)).
- R8: The select value (0 = system clock, 1 = audio clock) is taken only on clk_i edges where en_i is low and stopped_o is high. Values presented while running, or during the stop latency, are ignored.
- R9: stopped_o is low from the edge after en_i is sampled high with a nonzero ratio. It is high only once the selected divider is idle with the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| aud_clk_i | input | 1 | Audio clock, asynchronous to clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Clock enable |
| src_sel_i | input | 1 | Source select: 0 system, 1 audio |
| div_i | input | DIV_W | Ratio field; 0 disables the clock |
| sclk_o | output | 1 | Serial clock pin |
| stopped_o | output | 1 | High when the clock is fully stopped |

## Verification
A counter fault in the divider shows up on the first full pin period as a wrong period or a wrong high time. A fault in the stop pipeline depth shows up within a few edges after the enable falls: the pin either stops toggling one edge early or makes an extra rising edge. A source latch that takes a value it should have ignored only becomes visible at the next restart, when the pin runs at the other source's period. A stop that cuts a pulse short leaves a final high phase shorter than half the period.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic {SRC_SYS = 1'b0, SRC_AUD = 1'b1} sclk_src_e;
  // stop/start pipeline depth in source cycles; fixes the R4/R5 latency
  localparam int unsigned SCLK_PIPE = 3;
endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/sclk_div.sv
module sclk_div #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o,
  output logic             idle_o
);
  localparam int unsigned CW = DIV_W + 1;

  logic [STAGES-1:0] pipe_q, pipe_d;
  logic [DIV_W-1:0]  cnt_q, cnt_nxt, cnt_d;
  logic [CW-1:0]     n_w, h_w, lo_w;
  logic              ck_q, ck_d, hi_nxt, run, adv, wrap, idle_q;

  // request pipe; first stage also synchronises a foreign request
  assign pipe_d = {pipe_q[STAGES-2:0], req_i};
  assign run    = pipe_q[STAGES-1];

  assign n_w    = {1'b0, div_i} + CW'(1);
  assign h_w    = n_w >> 1;
  assign lo_w   = n_w - h_w;
  assign wrap   = (cnt_q >= div_i);
  assign cnt_nxt = wrap ? '0 : cnt_q + DIV_W'(1);
  assign hi_nxt = ({1'b0, cnt_nxt} >= lo_w);

  // keep counting after run drops until a high phase is finished
  assign adv   = run | ck_q;
  assign ck_d  = adv ? hi_nxt  : 1'b0;
  assign cnt_d = adv ? cnt_nxt : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      cnt_q  <= '0;
      ck_q   <= 1'b0;
      idle_q <= 1'b1;
    end else begin
      pipe_q <= pipe_d;
      cnt_q  <= cnt_d;
      ck_q   <= ck_d;
      idle_q <= ~|pipe_d & ~ck_d;
    end
  end

  assign clk_o  = ck_q;
  assign idle_o = idle_q;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             aud_clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             src_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             stopped_o
);
  localparam int unsigned NSRC = 2;

  logic            req_q;
  sclk_src_e       src_q;
  logic [NSRC-1:0] src_clk, src_req, src_ck, src_idle, idle_sys;

  assign src_clk = {aud_clk_i, clk_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= en_i & (div_i != '0);
  end

  // source latch only opens when disabled and fully stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 src_q <= SRC_SYS;
    else if (!en_i && stopped_o) src_q <= sclk_src_e'(src_sel_i);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_req[g] = req_q & (int'(src_q) == g);

    sclk_div #(
      .DIV_W  (DIV_W),
      .STAGES (SCLK_PIPE)
    ) u_div (
      .clk_i  (src_clk[g]),
      .rst_ni (rst_ni),
      .req_i  (src_req[g]),
      .div_i  (div_i),
      .clk_o  (src_ck[g]),
      .idle_o (src_idle[g])
    );

    if (g == 0) begin : g_local
      assign idle_sys[g] = src_idle[g];
    end else begin : g_cross
      sclk_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
      ) u_idle_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (src_idle[g]),
        .q_o    (idle_sys[g])
      );
    end
  end

  // only one divider can be active; both are low when the source changes
  assign sclk_o    = |src_ck;
  assign stopped_o = ~req_q & ((src_q == SRC_AUD) ? idle_sys[1] : idle_sys[0]);
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk
  import sclk_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [DIV_W-1:0] div_i,
  input logic             sclk_o,
  input logic             stopped_o,
  input sclk_src_e        src_q
);
  p_stop_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stopped_o |-> !sclk_o);

  p_run_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && div_i != '0) |=> !stopped_o);

  p_zero_div_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_o && div_i == '0) |=> stopped_o);

  p_src_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stopped_o || en_i) |=> $stable(src_q));

  p_sys_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q == SRC_SYS && !en_i && !$past(en_i) && !$past(en_i, 2) &&
     !$past(en_i, 3) && !$past(en_i, 4) && !$past(en_i, 5)) |-> !$rose(sclk_o));
endmodule

bind sclk_gen sclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .div_i     (div_i),
  .sclk_o    (sclk_o),
  .stopped_o (stopped_o),
  .src_q     (src_q)
);

// File: tb/sclk_gen_test.sv
`timescale 1ns/1ps
module sclk_gen_test;
  localparam int DIV_W = 8;
  localparam int T_SYS = 4;
  localparam int T_AUD = 14;

  logic clk = 1'b0, aud = 1'b0, rst_n = 1'b0, en = 1'b0, sel = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic sclk, stopped;

  int n_chk = 0, n_fail = 0;
  int rise_cnt = 0, last_hi = 0;
  realtime last_rise = 0;

  typedef struct { string tag; int per; int hi; } exp_t;
  exp_t sb_q[$];
  bit arm = 1'b0;

  always #2 clk = ~clk;
  initial begin
    #7 aud = 1'b1;
    forever #7 aud = ~aud;
  end

  sclk_gen #(.DIV_W(DIV_W)) uut (
    .clk_i(clk), .aud_clk_i(aud), .rst_ni(rst_n), .en_i(en),
    .src_sel_i(sel), .div_i(div), .sclk_o(sclk), .stopped_o(stopped)
  );

  always @(posedge sclk) begin rise_cnt++; last_rise = $realtime; end
  always @(negedge sclk) last_hi = int'($realtime - last_rise);

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // monitor: measure one full pin period per queued item
  initial begin
    realtime t_r, t_f;
    exp_t it;
    forever begin
      @(posedge sclk);
      if (arm && sb_q.size() > 0) begin
        t_r = $realtime;
        @(negedge sclk);
        t_f = $realtime;
        @(posedge sclk);
        if (sb_q.size() > 0) begin
          it = sb_q.pop_front();
          chk(it.tag, "period ns", int'($realtime - t_r), it.per);
          chk(it.tag, "high ns", int'(t_f - t_r), it.hi);
        end
      end
    end
  end

  task automatic at_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_stopped(string rq);
    int k = 0;
    while (!stopped && k < 200) begin @(negedge clk); k++; end
    chk(rq, "stopped_o after stop", int'(stopped), 1);
  endtask

  task automatic stop_clk(string rq);
    @(negedge clk) en = 1'b0;
    wait_stopped(rq);
    at_neg(2);
  endtask

  task automatic start_clk(int d);
    @(negedge clk);
    div = DIV_W'(d);
    en  = 1'b1;
  endtask

  task automatic expect_clk(string tag, int per, int hi, int n);
    int k = 0;
    exp_t it;
    for (int i = 0; i < n; i++) begin
      it.tag = tag; it.per = per; it.hi = hi;
      sb_q.push_back(it);
    end
    arm = 1'b1;
    while (sb_q.size() > 0 && k < 5000) begin @(negedge clk); k++; end
    if (sb_q.size() > 0) begin
      chk(tag, "scoreboard items left", sb_q.size(), 0);
      sb_q.delete();
    end
    arm = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int r0, v2, v3;
    realtime t0;
    int ds[5] = '{1, 2, 3, 6, 255};

    at_neg(3);
    rst_n = 1'b1;
    at_neg(1);
    chk("R1", "sclk_o after reset", int'(sclk), 0);
    chk("R1", "stopped_o after reset", int'(stopped), 1);

    // R3: zero ratio keeps pin low with enable high
    start_clk(0);
    r0 = rise_cnt;
    at_neg(40);
    chk("R3", "rising edges with zero ratio", rise_cnt - r0, 0);
    chk("R3", "stopped_o with zero ratio", int'(stopped), 1);
    chk("R3", "sclk_o with zero ratio", int'(sclk), 0);
    stop_clk("R3");

    // R2 system source, several ratios
    foreach (ds[i]) begin
      start_clk(ds[i]);
      expect_clk("R2", T_SYS * (ds[i] + 1), T_SYS * ((ds[i] + 1) / 2), (ds[i] > 100) ? 1 : 3);
      chk("R9", "stopped_o while running", int'(stopped), 0);
      stop_clk("R9");
    end

    // R7: start latency and leading low phase, N=4
    @(negedge clk);
    div = DIV_W'(3); en = 1'b1;
    t0 = $realtime + 2;
    r0 = rise_cnt;
    for (int k = 0; k < 50 && rise_cnt == r0; k++) @(negedge clk);
    chk("R7", "first rise after start ns", int'(last_rise - t0), 5 * T_SYS);
    stop_clk("R7");

    // R4 stop latency (system), with R8 select pulses that must be ignored
    start_clk(1);
    at_neg(10);
    sel = 1'b1;
    at_neg(1);
    sel = 1'b0;
    at_neg(2);
    en = 1'b0;                 // edge 0 is the next posedge
    @(negedge clk) sel = 1'b1; // after edge 0
    chk("R9", "stopped_o during stop latency", int'(stopped), 0);
    @(negedge clk) sel = 1'b0; // after edge 1
    chk("R9", "stopped_o during stop latency", int'(stopped), 0);
    @(negedge clk) v2 = int'(sclk); // after edge 2
    @(negedge clk) v3 = int'(sclk); // after edge 3
    chk("R4", "toggle on edge 3", v2 ^ v3, 1);
    @(negedge clk);                 // after edge 4
    chk("R4", "sclk_o after edge 4", int'(sclk), 0);
    r0 = rise_cnt;
    @(negedge clk);
    chk("R9", "stopped_o after stop", int'(stopped), 1);
    at_neg(10);
    chk("R4", "rising edges after edge 4", rise_cnt - r0, 0);

    // R8: source must still be the system clock
    start_clk(1);
    expect_clk("R8", 2 * T_SYS, T_SYS, 2);
    stop_clk("R8");

    // R6: stop at various phases, N=8
    for (int k = 0; k < 6; k++) begin
      start_clk(7);
      at_neg(13 + k);
      stop_clk("R6");
      chk("R6", "last high pulse ns (system)", last_hi, 4 * T_SYS);
      chk("R6", "sclk_o after stop", int'(sclk), 0);
    end

    // R8: select taken while stopped
    @(negedge clk) sel = 1'b1;
    at_neg(2);
    start_clk(1);
    expect_clk("R8", 2 * T_AUD, T_AUD, 2);
    stop_clk("R8");
    start_clk(4);
    expect_clk("R2", 5 * T_AUD, 2 * T_AUD, 2);
    stop_clk("R2");

    // R5 stop latency (audio)
    start_clk(1);
    at_neg(30);
    en = 1'b0;
    @(posedge clk);            // edge 0
    @(posedge aud);
    @(posedge aud);
    #1 v2 = int'(sclk);
    @(posedge aud);
    #1 v3 = int'(sclk);
    chk("R5", "toggle on third audio edge", v2 ^ v3, 1);
    @(posedge aud);
    #1;
    chk("R5", "sclk_o after fourth audio edge", int'(sclk), 0);
    r0 = rise_cnt;
    repeat (5) @(posedge aud);
    #1;
    chk("R5", "rising edges after fourth audio edge", rise_cnt - r0, 0);
    @(negedge clk);
    wait_stopped("R5");
    at_neg(2);

    // R6 audio, N=8
    start_clk(7);
    at_neg(97);
    stop_clk("R6");
    chk("R6", "last high pulse ns (audio)", last_hi, 4 * T_AUD);

    summary();
    $finish;
  end
endmodule